// File: doc/BRIEF.md
# Quadrature Down-Mixer with Rotation-Based Oscillator

This block translates a real intermediate-frequency sample stream to complex baseband. Each accepted 14-bit input sample is multiplied by the cosine and the sine of a running phase. The result is a pair of 16-bit in-phase and quadrature samples. The running phase comes from a 32-bit phase accumulator that advances by a programmable tuning word. At a 61.44 MSPS sample rate its step is about 0.014 Hz, far below the required quarter-hertz resolution.

The sine and cosine are not read from a stored table. The two top phase bits select a quadrant. The remaining bits are rotated by a chain of shift-and-add micro-rotation stages, one register per stage. The quadrant signs are applied at the end. The starting vector length already includes the inverse of the rotation gain, so no gain-correction multiplier is needed. The input sample travels beside the rotation pipeline, which keeps it aligned with its own phase. A fixed-latency valid tag marks the outputs. There is one tuning word and one output pair, meant for a single-carrier receive path ahead of the decimating filters.

Top module: `ddc_quad_mixer`

## Requirements
- R1: Reset (rst_ni low) clears the phase accumulator and all valid tags. iq_valid_o, i_o and q_o read 0 during reset, and iq_valid_o stays low until a sample accepted after reset has crossed the pipeline. The first sample accepted after reset is mixed with phase 0.
- R2: Every cycle with smp_valid_i high produces exactly one cycle of iq_valid_o, 19 clock cycles after the edge that sampled it. No other iq_valid_o pulses occur.
- R3: The phase used for accepted sample n is the sum, modulo 2^32, of the ftw_i values present with accepted samples 0..n-1. A changed tuning word therefore first affects the sample after the one it arrives with.
- R4: i_o is round(4 · x · cos(2π·φ/2^32)), where x is the signed two's-complement sample and φ the phase of R3 (upper 24 bits used), with an error of at most 6 LSB.
- R5: q_o is round(4 · x · sin(2π·φ/2^32)) with the same phase and the same error bound.
- R6: The results of R4 and R5 hold in all four quadrants of the phase, including phases that are not on an axis.
- R7: Results beyond the 16-bit signed range clamp to 32767 or -32768 and never wrap.
- R8: A zero input sample yields exactly 0 on both i_o and q_o.
- R9: Cycles with smp_valid_i low do not advance the phase, whatever ftw_i holds in those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ftw_i | input | 32 | Phase increment per accepted sample, unsigned fraction of a turn |
| smp_valid_i | input | 1 | Input sample strobe |
| smp_i | input | 14 | Real input sample, signed |
| iq_valid_o | output | 1 | Output pair strobe |
| i_o | output | 16 | In-phase result, signed |
| q_o | output | 16 | Quadrature result, signed |

## Verification
The bench drives samples with -8192 at the phases 0, 180 and 270 degrees. A product rounded or clamped incorrectly would wrap to the opposite sign there and miss the expected value by about 65536. A four-step quadrant sweep at non-axis angles catches swapped or wrongly signed sine and cosine restoration, which would give values far from the reference in one quadrant only. Idle gaps carrying a garbage tuning word show whether the accumulator moves without a valid sample. A tuning-word change mid-stream shows whether the new word is applied one sample too early. A reset issued mid-run must restart the phase from zero and must not release stale valid tags.

// File: rtl/ddc_mix_pkg.sv
`timescale 1ns/1ps
package ddc_mix_pkg;

    // Angle width used inside the rotator: one full turn equals 2^32.
    localparam int unsigned Z_W = 32;

    // Inverse rotation gain 0.6072529350 scaled by 2^30.
    localparam logic [31:0] INV_GAIN_Q30 = 32'd652032874;

    // atan(2^-idx) expressed in units of 2^-32 turn.
    function automatic logic [Z_W-1:0] atan_turn(input int unsigned idx);
        case (idx)
            0:       return 32'd536870912;
            1:       return 32'd316933406;
            2:       return 32'd167458907;
            3:       return 32'd85004756;
            4:       return 32'd42667331;
            5:       return 32'd21354465;
            6:       return 32'd10679838;
            7:       return 32'd5340245;
            8:       return 32'd2670163;
            9:       return 32'd1335087;
            10:      return 32'd667544;
            11:      return 32'd333772;
            12:      return 32'd166886;
            13:      return 32'd83443;
            14:      return 32'd41722;
            default: return 32'd41722 >> (idx - 14);
        endcase
    endfunction

endpackage

// File: rtl/ddc_phase_acc.sv
`timescale 1ns/1ps
module ddc_phase_acc #(
    parameter int unsigned PHASE_W = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               step_i,
    input  logic [PHASE_W-1:0] ftw_i,
    output logic [PHASE_W-1:0] acc_o
);

    typedef struct packed {
        logic [PHASE_W-1:0] acc;
    } acc_st_t;

    acc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            st_d.acc = st_q.acc + ftw_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o = st_q.acc;

endmodule

// File: rtl/ddc_cordic_stage.sv
`timescale 1ns/1ps
module ddc_cordic_stage
    import ddc_mix_pkg::*;
#(
    parameter int unsigned IDX  = 0,
    parameter int unsigned CW   = 21,
    parameter int unsigned IN_W = 14
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic signed [CW-1:0]   x_i,
    input  logic signed [CW-1:0]   y_i,
    input  logic signed [Z_W-1:0]  z_i,
    input  logic signed [IN_W-1:0] smp_i,
    input  logic [1:0]             quad_i,
    input  logic                   vld_i,
    output logic signed [CW-1:0]   x_o,
    output logic signed [CW-1:0]   y_o,
    output logic signed [Z_W-1:0]  z_o,
    output logic signed [IN_W-1:0] smp_o,
    output logic [1:0]             quad_o,
    output logic                   vld_o
);

    localparam logic signed [Z_W-1:0] ATAN = $signed(atan_turn(IDX));

    typedef struct packed {
        logic signed [CW-1:0]   x;
        logic signed [CW-1:0]   y;
        logic signed [Z_W-1:0]  z;
        logic signed [IN_W-1:0] smp;
        logic [1:0]             quad;
        logic                   vld;
    } stage_st_t;

    stage_st_t st_d, st_q;
    logic signed [CW-1:0] x_sh, y_sh;

    assign x_sh = x_i >>> IDX;
    assign y_sh = y_i >>> IDX;

    always_comb begin
        st_d      = st_q;
        st_d.smp  = smp_i;
        st_d.quad = quad_i;
        st_d.vld  = vld_i;
        if (!z_i[Z_W-1]) begin
            // remaining angle positive: rotate counter-clockwise
            st_d.x = x_i - y_sh;
            st_d.y = y_i + x_sh;
            st_d.z = z_i - ATAN;
        end else begin
            st_d.x = x_i + y_sh;
            st_d.y = y_i - x_sh;
            st_d.z = z_i + ATAN;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign x_o    = st_q.x;
    assign y_o    = st_q.y;
    assign z_o    = st_q.z;
    assign smp_o  = st_q.smp;
    assign quad_o = st_q.quad;
    assign vld_o  = st_q.vld;

endmodule

// File: rtl/ddc_cordic_rot.sv
`timescale 1ns/1ps
module ddc_cordic_rot
    import ddc_mix_pkg::*;
#(
    parameter int unsigned IN_W   = 14,
    parameter int unsigned ANG_W  = 24,
    parameter int unsigned FRAC   = 18,
    parameter int unsigned STAGES = 16,
    localparam int unsigned CW    = FRAC + 3
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [ANG_W-1:0]       phase_i,
    input  logic signed [IN_W-1:0] smp_i,
    input  logic                   vld_i,
    output logic signed [CW-1:0]   cos_o,
    output logic signed [CW-1:0]   sin_o,
    output logic signed [IN_W-1:0] smp_o,
    output logic                   vld_o
);

    // Start length = inverse gain, so the rotated vector ends near 2^FRAC.
    localparam longint unsigned X0_L = (64'(INV_GAIN_Q30) << FRAC) >> 30;
    localparam logic signed [CW-1:0] X0 = $signed(CW'(X0_L));

    // ---------------- quadrant fold register ----------------
    typedef struct packed {
        logic signed [CW-1:0]   x;
        logic signed [CW-1:0]   y;
        logic signed [Z_W-1:0]  z;
        logic signed [IN_W-1:0] smp;
        logic [1:0]             quad;
        logic                   vld;
    } fold_st_t;

    fold_st_t fold_d, fold_q;
    logic [Z_W-1:0] z_res;

    assign z_res = Z_W'(phase_i[ANG_W-3:0]) << (Z_W - ANG_W);

    always_comb begin
        fold_d      = fold_q;
        fold_d.x    = X0;
        fold_d.y    = '0;
        fold_d.z    = $signed(z_res);
        fold_d.smp  = smp_i;
        fold_d.quad = phase_i[ANG_W-1 -: 2];
        fold_d.vld  = vld_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fold_q <= '0;
        end else begin
            fold_q <= fold_d;
        end
    end

    // ---------------- micro-rotation chain ----------------
    logic signed [CW-1:0]   xa   [STAGES+1];
    logic signed [CW-1:0]   ya   [STAGES+1];
    logic signed [Z_W-1:0]  za   [STAGES+1];
    logic signed [IN_W-1:0] sa   [STAGES+1];
    logic [1:0]             qa   [STAGES+1];
    logic                   va   [STAGES+1];

    assign xa[0] = fold_q.x;
    assign ya[0] = fold_q.y;
    assign za[0] = fold_q.z;
    assign sa[0] = fold_q.smp;
    assign qa[0] = fold_q.quad;
    assign va[0] = fold_q.vld;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        ddc_cordic_stage #(
            .IDX  (k),
            .CW   (CW),
            .IN_W (IN_W)
        ) u_stage (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .x_i    (xa[k]),
            .y_i    (ya[k]),
            .z_i    (za[k]),
            .smp_i  (sa[k]),
            .quad_i (qa[k]),
            .vld_i  (va[k]),
            .x_o    (xa[k+1]),
            .y_o    (ya[k+1]),
            .z_o    (za[k+1]),
            .smp_o  (sa[k+1]),
            .quad_o (qa[k+1]),
            .vld_o  (va[k+1])
        );
    end

    // ---------------- quadrant restore register ----------------
    typedef struct packed {
        logic signed [CW-1:0]   c;
        logic signed [CW-1:0]   s;
        logic signed [IN_W-1:0] smp;
        logic                   vld;
    } rest_st_t;

    rest_st_t rest_d, rest_q;
    logic signed [CW-1:0] x_end, y_end;

    assign x_end = xa[STAGES];
    assign y_end = ya[STAGES];

    always_comb begin
        rest_d     = rest_q;
        rest_d.smp = sa[STAGES];
        rest_d.vld = va[STAGES];
        unique case (qa[STAGES])
            2'd0: begin rest_d.c =  x_end; rest_d.s =  y_end; end
            2'd1: begin rest_d.c = -y_end; rest_d.s =  x_end; end
            2'd2: begin rest_d.c = -x_end; rest_d.s = -y_end; end
            default: begin rest_d.c = y_end; rest_d.s = -x_end; end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rest_q <= '0;
        end else begin
            rest_q <= rest_d;
        end
    end

    assign cos_o = rest_q.c;
    assign sin_o = rest_q.s;
    assign smp_o = rest_q.smp;
    assign vld_o = rest_q.vld;

endmodule

// File: rtl/ddc_iq_mult.sv
`timescale 1ns/1ps
module ddc_iq_mult #(
    parameter int unsigned IN_W  = 14,
    parameter int unsigned CW    = 21,
    parameter int unsigned FRAC  = 18,
    parameter int unsigned OUT_W = 16
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic signed [CW-1:0]    cos_i,
    input  logic signed [CW-1:0]    sin_i,
    input  logic signed [IN_W-1:0]  smp_i,
    input  logic                    vld_i,
    output logic signed [OUT_W-1:0] i_o,
    output logic signed [OUT_W-1:0] q_o,
    output logic                    vld_o
);

    localparam int unsigned SH = FRAC - (OUT_W - IN_W);
    localparam int unsigned PW = IN_W + CW;
    localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
    localparam logic signed [PW-1:0] MINV = PW'(-(64'sd1 <<< (OUT_W - 1)));
    localparam logic signed [PW-1:0] HALF = PW'(64'sd1 <<< (SH - 1));

    function automatic logic signed [OUT_W-1:0] mix_round(
        input logic signed [IN_W-1:0] a,
        input logic signed [CW-1:0]   b
    );
        logic signed [PW-1:0] p;
        logic signed [PW-1:0] r;
        p = PW'(a) * PW'(b);
        r = (p + HALF) >>> SH;
        if (r > MAXV) begin
            return MAXV[OUT_W-1:0];
        end else if (r < MINV) begin
            return MINV[OUT_W-1:0];
        end
        return r[OUT_W-1:0];
    endfunction

    typedef struct packed {
        logic signed [OUT_W-1:0] i;
        logic signed [OUT_W-1:0] q;
        logic                    vld;
    } mult_st_t;

    mult_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.i   = mix_round(smp_i, cos_i);
        st_d.q   = mix_round(smp_i, sin_i);
        st_d.vld = vld_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign i_o   = st_q.i;
    assign q_o   = st_q.q;
    assign vld_o = st_q.vld;

endmodule

// File: rtl/ddc_quad_mixer.sv
`timescale 1ns/1ps
module ddc_quad_mixer #(
    parameter int unsigned IN_W    = 14,
    parameter int unsigned OUT_W   = 16,
    parameter int unsigned PHASE_W = 32,
    parameter int unsigned ANG_W   = 24,
    parameter int unsigned FRAC    = 18,
    parameter int unsigned STAGES  = 16
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [PHASE_W-1:0]      ftw_i,
    input  logic                    smp_valid_i,
    input  logic signed [IN_W-1:0]  smp_i,
    output logic                    iq_valid_o,
    output logic signed [OUT_W-1:0] i_o,
    output logic signed [OUT_W-1:0] q_o
);

    localparam int unsigned CW = FRAC + 3;

    logic [PHASE_W-1:0]     acc_w;
    logic signed [CW-1:0]   cos_w, sin_w;
    logic signed [IN_W-1:0] smp_w;
    logic                   vld_w;

    ddc_phase_acc #(
        .PHASE_W (PHASE_W)
    ) u_acc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .step_i (smp_valid_i),
        .ftw_i  (ftw_i),
        .acc_o  (acc_w)
    );

    ddc_cordic_rot #(
        .IN_W   (IN_W),
        .ANG_W  (ANG_W),
        .FRAC   (FRAC),
        .STAGES (STAGES)
    ) u_rot (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .phase_i (acc_w[PHASE_W-1 -: ANG_W]),
        .smp_i   (smp_i),
        .vld_i   (smp_valid_i),
        .cos_o   (cos_w),
        .sin_o   (sin_w),
        .smp_o   (smp_w),
        .vld_o   (vld_w)
    );

    ddc_iq_mult #(
        .IN_W  (IN_W),
        .CW    (CW),
        .FRAC  (FRAC),
        .OUT_W (OUT_W)
    ) u_mult (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cos_i  (cos_w),
        .sin_i  (sin_w),
        .smp_i  (smp_w),
        .vld_i  (vld_w),
        .i_o    (i_o),
        .q_o    (q_o),
        .vld_o  (iq_valid_o)
    );

endmodule

// File: rtl/ddc_quad_mixer_chk.sv
`timescale 1ns/1ps
module ddc_quad_mixer_chk #(
    parameter int unsigned IN_W    = 14,
    parameter int unsigned OUT_W   = 16,
    parameter int unsigned PHASE_W = 32,
    parameter int unsigned LAT     = 19
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic [PHASE_W-1:0]      ftw_i,
    input logic                    smp_valid_i,
    input logic signed [IN_W-1:0]  smp_i,
    input logic [PHASE_W-1:0]      acc_i,
    input logic                    iq_valid_o,
    input logic signed [OUT_W-1:0] i_o,
    input logic signed [OUT_W-1:0] q_o
);

    localparam int unsigned FW = $clog2(LAT + 1);

    logic [LAT-1:0] vpipe;
    logic [LAT-1:0] zpipe;
    logic [FW-1:0]  fill;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            vpipe <= '0;
            zpipe <= '0;
            fill  <= '0;
        end else begin
            vpipe <= {vpipe[LAT-2:0], smp_valid_i};
            zpipe <= {zpipe[LAT-2:0], (smp_i == '0)};
            if (fill != FW'(LAT)) begin
                fill <= fill + 1'b1;
            end
        end
    end

    // R1: nothing valid leaves before the pipeline has filled
    p_no_early_valid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fill < FW'(LAT)) |-> !iq_valid_o);

    // R2: output strobe is the input strobe delayed by the fixed latency
    p_valid_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        iq_valid_o == vpipe[LAT-1]);

    // R3: accepted sample advances the phase by the tuning word
    p_acc_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smp_valid_i |=> (acc_i == $past(acc_i) + $past(ftw_i)));

    // R9: idle cycles leave the phase untouched
    p_acc_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !smp_valid_i |=> $stable(acc_i));

    // R8: zero sample in, zero pair out
    p_zero_out_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (iq_valid_o && zpipe[LAT-1]) |-> (i_o == '0 && q_o == '0));

endmodule

bind ddc_quad_mixer ddc_quad_mixer_chk #(
    .IN_W    (IN_W),
    .OUT_W   (OUT_W),
    .PHASE_W (PHASE_W),
    .LAT     (STAGES + 3)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ftw_i       (ftw_i),
    .smp_valid_i (smp_valid_i),
    .smp_i       (smp_i),
    .acc_i       (acc_w),
    .iq_valid_o  (iq_valid_o),
    .i_o         (i_o),
    .q_o         (q_o)
);

// File: tb/ddc_quad_mixer_tb_top.sv
`timescale 1ns/1ps
module ddc_quad_mixer_tb_top;

    localparam int LAT = 19;
    localparam int TOL = 6;
    localparam int DEPTH = 256;

    typedef struct packed {
        logic [31:0]        f;
        logic signed [13:0] s;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{32'h0A3D_70A4,  14'sd8191},
        '{32'h0A3D_70A4,  14'sh2000},
        '{32'h0A3D_70A4,  14'sd1234},
        '{32'h1555_5555, -14'sd3000},
        '{32'h1555_5555,  14'sd0},
        '{32'h7FFF_FFFF,  14'sd4095},
        '{32'h8000_0001,  14'sh3FFF},
        '{32'hF000_0000,  14'sd6000},
        '{32'h0000_0001, -14'sd5555},
        '{32'h0000_0001,  14'sd7777},
        '{32'h3333_3333,  14'sd2048},
        '{32'hC000_0000, -14'sd8000}
    };

    logic               clk;
    logic               rst_n;
    logic [31:0]        ftw;
    logic               smp_valid;
    logic signed [13:0] smp;
    logic               iq_valid;
    logic signed [15:0] i_out, q_out;

    int checks;
    int errors;
    int cyc;
    bit done;

    int    exp_i   [DEPTH];
    int    exp_q   [DEPTH];
    int    exp_cyc [DEPTH];
    int    exp_tol [DEPTH];
    string exp_ctx [DEPTH];
    int    wr, rd;
    longint unsigned m_acc;

    ddc_quad_mixer dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .ftw_i       (ftw),
        .smp_valid_i (smp_valid),
        .smp_i       (smp),
        .iq_valid_o  (iq_valid),
        .i_o         (i_out),
        .q_o         (q_out)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int ref_mix(input int s, input longint unsigned a, input bit use_sin);
        real ph, v;
        int  r;
        ph = 6.283185307179586 * real'(a) / 4294967296.0;
        v  = 4.0 * real'(s) * (use_sin ? $sin(ph) : $cos(ph));
        r  = int'($floor(v + 0.5));
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic check_eq(input string req, input int act, input int exp, input int tol);
        int d;
        checks++;
        d = act - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input logic signed [13:0] s, input logic [31:0] f, input string ctx);
        @(negedge clk);
        smp_valid = 1'b1;
        smp       = s;
        ftw       = f;
        exp_i[wr % DEPTH]   = ref_mix(int'(s), m_acc, 1'b0);
        exp_q[wr % DEPTH]   = ref_mix(int'(s), m_acc, 1'b1);
        exp_cyc[wr % DEPTH] = cyc;
        exp_tol[wr % DEPTH] = (s == 0) ? 0 : TOL;
        exp_ctx[wr % DEPTH] = ctx;
        wr++;
        m_acc = (m_acc + longint'(f)) & 64'hFFFF_FFFF;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            smp_valid = 1'b0;
            smp       = 14'sd1111;
            ftw       = 32'hDEAD_BEEF;
        end
    endtask

    // Output monitor: compares every emitted pair with the reference queue
    always @(negedge clk) begin
        if (rst_n && iq_valid) begin
            if (rd == wr) begin
                checks++;
                errors++;
                $display("FAIL R2: actual unexpected valid output, expected none");
            end else begin
                check_eq({"R2 latency ", exp_ctx[rd % DEPTH]}, cyc - exp_cyc[rd % DEPTH], LAT, 0);
                check_eq({"R4 I ", exp_ctx[rd % DEPTH]}, int'(i_out), exp_i[rd % DEPTH], exp_tol[rd % DEPTH]);
                check_eq({"R5 Q ", exp_ctx[rd % DEPTH]}, int'(q_out), exp_q[rd % DEPTH], exp_tol[rd % DEPTH]);
                rd++;
            end
        end
    end

    initial begin
        checks = 0; errors = 0; cyc = 0; done = 1'b0;
        wr = 0; rd = 0; m_acc = 0;
        rst_n = 1'b0; smp_valid = 1'b0; smp = '0; ftw = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_eq("R1 reset valid", int'(iq_valid), 0, 0);
        check_eq("R1 reset I", int'(i_out), 0, 0);
        check_eq("R1 reset Q", int'(q_out), 0, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table walk (R3 tuning changes, R4, R5, R8 zero entry)
        for (int v = 0; v < 12; v++) begin
            push(VEC[v].s, VEC[v].f, "table R3");
        end
        idle(LAT + 4);

        // R6: four quadrants at non-axis angles
        for (int k = 0; k < 5; k++) begin
            push(14'sd5000, 32'h4800_0000, "quadrant R6");
        end
        idle(3);

        // R9: gaps with a garbage tuning word must not move the phase
        push(14'sd3000, 32'h1234_5678, "gap R9");
        idle(5);
        push(-14'sd3000, 32'h1234_5678, "gap R9");
        idle(7);
        push(14'sd2500, 32'h0FED_CBA9, "gap R9");
        idle(1);

        // R3: tuning word change applies from the following sample
        push(14'sd4000, 32'h2000_0000, "ftw R3");
        push(14'sd4000, 32'h0100_0000, "ftw R3");
        push(14'sd4000, 32'h0100_0000, "ftw R3");
        push(14'sd0,    32'h0100_0000, "zero R8");
        push(-14'sd4000, 32'h0, "ftw R3");
        idle(LAT + 4);
        check_eq("R2 all outputs delivered", rd, wr, 0);

        // R1: mid-run reset restarts phase at zero
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_eq("R1 reset valid", int'(iq_valid), 0, 0);
        check_eq("R1 reset I", int'(i_out), 0, 0);
        m_acc = 0;
        rst_n = 1'b1;
        push(14'sd5000, 32'h0, "reset R1");
        // R7: saturation at 0, 180 and 270 degrees with the most negative sample
        push(14'sh2000, 32'h8000_0000, "sat R7");
        push(14'sh2000, 32'h4000_0000, "sat R7");
        push(14'sh2000, 32'h0, "sat R7");
        push(14'sd8191, 32'h0, "sat R7");
        idle(LAT + 4);
        check_eq("R2 all outputs delivered", rd, wr, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule